// File: doc/BRIEF.md
# Hamming Helper-Data Response Corrector

This block steadies a noisy device fingerprint using Hamming parity that was saved earlier as helper data. The fingerprint moves through it in 4-bit chunks. Every input beat carries a mode bit.

In **enroll** mode the chunk is the majority-voted reference response. The block returns the parity nibble for that chunk, which the system keeps in external storage. In **reconstruct** mode the chunk is a fresh, noisy read. It arrives with the parity nibble stored for the same chunk. The block forms the 7-bit (or 8-bit) codeword, computes the syndrome, and returns the corrected data together with status flags.

The helper parity is produced once and paired with new reads later, so it never travels with the data. A per-beat SECDED select adds an overall parity bit. With it, double flips are reported instead of being "fixed" at an aliased position.

For a 2048-bit response the three-bit code gives 1536 helper bits. SECDED adds one more bit per chunk. Both sides use a valid/ready handshake, and the block produces exactly one result per accepted chunk.

Top module: `hamming_helper_corrector`

## Requirements
- R1: Codeword positions 1, 2 and 4 hold parity and positions 3, 5, 6 and 7 hold data bits d0..d3. In enroll mode the output parity is as follows: out_parity[0] = d0^d1^d3 (position 1), out_parity[1] = d0^d2^d3 (position 2), out_parity[2] = d1^d2^d3 (position 4). out_data echoes the input chunk.
- R2: In enroll mode with SECDED selected, out_parity[3] is the overall parity bit (position 0). It is the XOR of d0..d3 and the three parity bits. With SECDED off, out_parity[3] is 0.
- R3: In reconstruct mode with no flipped bit, out_data equals the input data and both flags are 0.
- R4: In reconstruct mode with exactly one flipped data bit, the original data is restored and out_corrected is 1.
- R5: In reconstruct mode with exactly one flipped bit at parity position 1, 2 or 4, out_data equals the input data and out_corrected is 1.
- R6: In SECDED mode with two flipped bits (positions 0..7), meaning a nonzero syndrome with even overall parity, out_data equals the noisy input data, out_double is 1 and out_corrected is 0.
- R7: With SECDED off, in_parity[3] is ignored. Two flips at positions a and b (1..7) flip the bit at position a XOR b, and out_corrected is 1. out_double is never 1.
- R8: In SECDED mode with only position 0 flipped, out_data equals the input data and out_corrected is 1.
- R9: out_valid is 0 after reset. in_ready = !out_valid || out_ready. While out_valid is high and out_ready is low, all outputs hold stable. Each accepted chunk yields exactly one output, in order.
- R10: In reconstruct mode out_parity is 0. In enroll mode both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input chunk valid |
| in_ready | output | 1 | Block can accept a chunk |
| in_mode | input | 1 | 0 = enroll, 1 = reconstruct |
| in_secded | input | 1 | 1 = use overall parity bit (SECDED) |
| in_data | input | 4 | Data chunk d3..d0 |
| in_parity | input | 4 | Stored helper parity (reconstruct only) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_data | output | 4 | Echoed or corrected data |
| out_parity | output | 4 | Helper parity (enroll), else 0 |
| out_corrected | output | 1 | A single error was corrected |
| out_double | output | 1 | Uncorrectable double error (SECDED) |

## Verification
The bench injects every error pattern of weight zero, one and two over all eight codeword positions, in both modes and for several data values.

- A decoder that mixes up the position-to-bit mapping restores the wrong bit after a single flip.
- One that treats a parity-position syndrome as clean drops the corrected flag.
- One that ignores overall parity either miscorrects double flips or misses them.
- In SEC mode, a design that reads the overall bit anyway reports doubles it should alias.

Random output stalls check that a stalled result does not change. They also check that no chunk is lost or repeated when the stage accepts and releases in the same cycle.

// File: rtl/hhc_pkg.sv
package hhc_pkg;
    localparam int DATA_W = 4;
    localparam int CHK_W  = 3;
    localparam int HELP_W = CHK_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [HELP_W-1:0] par;
        logic              corr;
        logic              dbl;
    } hhc_result_t;
endpackage

// File: rtl/hhc_encoder.sv
module hhc_encoder
    import hhc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [HELP_W-1:0] par_o
);
    always_comb begin
        par_o[0] = data_i[0] ^ data_i[1] ^ data_i[3];
        par_o[1] = data_i[0] ^ data_i[2] ^ data_i[3];
        par_o[2] = data_i[1] ^ data_i[2] ^ data_i[3];
        par_o[3] = (^data_i) ^ (^par_o[CHK_W-1:0]);
    end
endmodule

// File: rtl/hhc_decoder.sv
module hhc_decoder
    import hhc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [HELP_W-1:0] par_i,
    input  logic              secded_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              dbl_o
);
    logic [HELP_W-1:0] enc;
    logic [CHK_W-1:0]  syn;
    logic              odd;
    logic [DATA_W-1:0] flip;

    hhc_encoder u_enc (.data_i(data_i), .par_o(enc));

    always_comb begin
        syn = par_i[CHK_W-1:0] ^ enc[CHK_W-1:0];
        odd = par_i[CHK_W] ^ enc[CHK_W] ^ (^syn);
    end

    // data bit k sits at codeword position 3,5,6,7
    for (genvar k = 0; k < DATA_W; k++) begin : g_pos
        localparam logic [CHK_W-1:0] POS = (k == 0) ? 3'd3 :
                                           (k == 1) ? 3'd5 :
                                           (k == 2) ? 3'd6 : 3'd7;
        assign flip[k] = (syn == POS);
    end

    always_comb begin
        data_o = data_i;
        corr_o = 1'b0;
        dbl_o  = 1'b0;
        if (secded_i) begin
            if (syn != '0 && !odd) begin
                dbl_o = 1'b1;
            end else if (syn != '0 || odd) begin
                corr_o = 1'b1;
                data_o = data_i ^ flip;
            end
        end else if (syn != '0) begin
            corr_o = 1'b1;
            data_o = data_i ^ flip;
        end
    end

    always_comb begin
        // R3
        if (syn == '0 && !odd) begin
            clean_pass_chk: assert (data_o == data_i && !corr_o && !dbl_o);
        end
        // R7
        if (!secded_i) begin
            sec_no_double_chk: assert (!dbl_o);
        end
    end
endmodule

// File: rtl/hhc_out_stage.sv
module hhc_out_stage
    import hhc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  hhc_result_t in_res,
    output logic        out_valid,
    input  logic        out_ready,
    output hhc_result_t out_res
);
    typedef struct packed {
        logic        valid;
        hhc_result_t res;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        in_ready = !st_q.valid || out_ready;
        st_d     = st_q;
        if (in_valid && in_ready) begin
            st_d.valid = 1'b1;
            st_d.res   = in_res;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_res   = st_q.res;

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));
    // R9
    accept_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/hamming_helper_corrector.sv
module hamming_helper_corrector
    import hhc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_mode,
    input  logic              in_secded,
    input  logic [DATA_W-1:0] in_data,
    input  logic [HELP_W-1:0] in_parity,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [HELP_W-1:0] out_parity,
    output logic              out_corrected,
    output logic              out_double
);
    logic [HELP_W-1:0] enr_par;
    logic [DATA_W-1:0] fix_data;
    logic              fix_corr, fix_dbl;
    hhc_result_t       res_d, res_q;

    hhc_encoder u_enroll (.data_i(in_data), .par_o(enr_par));

    hhc_decoder u_fix (
        .data_i(in_data), .par_i(in_parity), .secded_i(in_secded),
        .data_o(fix_data), .corr_o(fix_corr), .dbl_o(fix_dbl)
    );

    always_comb begin
        res_d = '0;
        if (in_mode) begin
            res_d.data = fix_data;
            res_d.corr = fix_corr;
            res_d.dbl  = fix_dbl;
        end else begin
            res_d.data = in_data;
            res_d.par  = enr_par;
            if (!in_secded) res_d.par[CHK_W] = 1'b0;
        end
    end

    hhc_out_stage u_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_res(res_d),
        .out_valid(out_valid), .out_ready(out_ready), .out_res(res_q)
    );

    assign out_data      = res_q.data;
    assign out_parity    = res_q.par;
    assign out_corrected = res_q.corr;
    assign out_double    = res_q.dbl;

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_corrected && out_double));
    // R10
    recon_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_corrected || out_double)) |-> (out_parity == '0));
endmodule

// File: tb/hamming_helper_corrector_tb.sv
module hamming_helper_corrector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_mode = 1'b0, in_secded = 1'b0, out_ready = 1'b0;
    logic [3:0] in_data = '0, in_parity = '0;
    logic       in_ready, out_valid, out_corrected, out_double;
    logic [3:0] out_data, out_parity;

    always #2.5 clk = ~clk;

    hamming_helper_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_secded(in_secded), .in_data(in_data),
        .in_parity(in_parity), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_parity(out_parity),
        .out_corrected(out_corrected), .out_double(out_double)
    );

    typedef struct {
        logic [3:0] d;
        logic [3:0] p;
        logic       c;
        logic       x;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, failures = 0, sent = 0, got = 0;
    bit done = 0;

    function automatic int dpos(int k);
        return (k == 0) ? 3 : (k == 1) ? 5 : (k == 2) ? 6 : 7;
    endfunction

    // R1/R2 parity model
    function automatic logic [3:0] enc(logic [3:0] d);
        logic [3:0] p;
        p[0] = d[0] ^ d[1] ^ d[3];
        p[1] = d[0] ^ d[2] ^ d[3];
        p[2] = d[1] ^ d[2] ^ d[3];
        p[3] = ^{d, p[2:0]};
        return p;
    endfunction

    // codeword bit i = position i
    function automatic logic [7:0] build(logic [3:0] d, logic [3:0] p);
        logic [7:0] w;
        w = '0;
        w[0] = p[3]; w[1] = p[0]; w[2] = p[1]; w[4] = p[2];
        for (int k = 0; k < 4; k++) w[dpos(k)] = d[k];
        return w;
    endfunction

    function automatic logic [3:0] wdata(logic [7:0] w);
        logic [3:0] d;
        for (int k = 0; k < 4; k++) d[k] = w[dpos(k)];
        return d;
    endfunction

    task automatic send(logic mode, logic sd, logic [3:0] d, logic [3:0] p, exp_t e);
        @(negedge clk);
        in_mode = mode; in_secded = sd; in_data = d; in_parity = p; in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        exp_q.push_back(e);
        sent++;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // monitor with random backpressure and hold check
    initial begin
        bit held = 0;
        logic [3:0] hd, hp;
        logic hc, hx;
        forever begin
            @(negedge clk);
            if (rst_n) out_ready = ($urandom_range(0, 3) != 0);
            #1;
            if (held) begin
                chk(out_valid && out_data == hd && out_parity == hp &&
                    out_corrected == hc && out_double == hx, "R9", "stall hold",
                    {out_data, out_parity}, {hd, hp});
            end
            held = 0;
            if (out_valid && !out_ready) begin
                held = 1; hd = out_data; hp = out_parity; hc = out_corrected; hx = out_double;
            end
            if (out_valid && out_ready) begin
                exp_t e;
                got++;
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected output", got, sent);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_data == e.d, e.tag, "data", out_data, e.d);
                    chk(out_parity == e.p, e.tag, "parity", out_parity, e.p);
                    chk({out_corrected, out_double} == {e.c, e.x}, e.tag, "flags c,x",
                        {out_corrected, out_double}, {e.c, e.x});
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] dv [5] = '{4'h0, 4'h5, 4'hA, 4'hF, 4'h9};
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(out_valid == 1'b0, "R9", "reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R9", "reset in_ready", in_ready, 1);
        rst_n = 1'b1;

        // R1 R2 R10 enroll sweep
        for (int sd = 0; sd < 2; sd++) begin
            for (int d = 0; d < 16; d++) begin
                exp_t e;
                logic [3:0] p;
                p = enc(4'(d));
                if (sd == 0) p[3] = 1'b0;
                e.d = 4'(d); e.p = p; e.c = 0; e.x = 0;
                e.tag = (sd != 0) ? "R2" : "R1";
                send(1'b0, sd[0], 4'(d), 4'hF, e);
            end
        end

        // reconstruct, error weight 0..2 over positions 0..7
        for (int sd = 0; sd < 2; sd++) begin
            for (int di = 0; di < 5; di++) begin
                for (int m = 0; m < 256; m++) begin
                    logic [7:0] w, nw, em, fw;
                    int n;
                    exp_t e;
                    if ($countones(m) > 2) continue;
                    w  = build(dv[di], enc(dv[di]));
                    nw = w ^ 8'(m);
                    em = (sd != 0) ? 8'(m) : (8'(m) & 8'hFE);
                    n  = $countones(em);
                    e.p = 4'h0; e.c = 0; e.x = 0;
                    if (n == 0) begin
                        e.d = wdata(nw);
                        e.tag = (m != 0) ? "R7" : "R3";
                    end else if (n == 1) begin
                        e.d = dv[di]; e.c = 1;
                        if (em[0]) e.tag = "R8";
                        else if (em[1] || em[2] || em[4]) e.tag = "R5";
                        else e.tag = "R4";
                    end else if (sd != 0) begin
                        e.d = wdata(nw); e.x = 1; e.tag = "R6";
                    end else begin
                        int a, b;
                        a = -1; b = -1;
                        for (int i = 1; i < 8; i++)
                            if (em[i]) begin if (a < 0) a = i; else b = i; end
                        fw = nw;
                        fw[a ^ b] = ~fw[a ^ b];
                        e.d = wdata(fw); e.c = 1; e.tag = "R7";
                    end
                    send(1'b1, sd[0], wdata(nw), {nw[0], nw[4], nw[2], nw[1]}, e);
                end
            end
        end

        // drain
        repeat (200) begin
            @(posedge clk);
            if (exp_q.size() == 0) break;
        end
        repeat (4) @(posedge clk);
        // R9 one output per accepted chunk
        chk(got == sent && exp_q.size() == 0, "R9", "output count", got, sent);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule